// File: doc/BRIEF.md
# Packet Header ECC Encoder and Single-Error Corrector

This block guards the 24-bit header of a camera-link packet with a 6-bit modified Hamming code. The header is made of an 8-bit data identifier and a 16-bit word count. A transmit path takes a header and returns the ECC byte to send with it. A separate receive path takes a header and the ECC byte that came with it. It recomputes the parity, forms a 6-bit syndrome and classifies the result. A single flipped header bit is repaired. A single flipped parity bit is reported as corrected, and the header is left as it arrived. Any other nonzero syndrome is reported as uncorrectable.

Both paths have one register stage. Each result appears one clock after its input beat and is qualified by its own valid output. The receive path raises exactly one of three status flags with every valid result, and none while idle.

Top module: `hdr_ecc_corrector`

## Requirements
- R1: The transmit ECC bits 5:0 are parity bits. Bit j is the XOR of every header bit i whose column code has bit j set. Header bits 0..19 take the twenty 6-bit codes with three set bits, in ascending numeric order (0x07, 0x0B, ..., 0x38). Header bits 20..23 take 0x1F, 0x2F, 0x37 and 0x3B.
- R2: Bits 7 and 6 of the transmitted ECC byte are always 0.
- R3: Header bit order is fixed. The data identifier fills bits 7:0, the low byte of the word count fills bits 15:8, and its high byte fills bits 23:16. For example, identifier 0x01 gives ECC 0x07, word count 0x0001 gives 0x1A, and word count 0x0100 gives 0x31.
- R4: The syndrome is the recomputed parity XOR the received ECC bits 5:0. When it is zero, the header is output unchanged with the ok flag set.
- R5: When the syndrome equals the column code of a header bit, that bit is inverted on output and the fixed flag is set.
- R6: When the syndrome has exactly one set bit, the error is taken to be in the ECC byte. The header is output unchanged and the fixed flag is set.
- R7: Any other nonzero syndrome sets the bad flag, and the header is output unchanged.
- R8: Received ECC bits 7:6 have no effect on the syndrome, the flags or the header output.
- R9: Each valid output rises exactly one clock after its valid input. While the receive valid output is high, exactly one of ok, fixed and bad is set. While it is low, all three are 0.
- R10: While reset is held low, both valid outputs and all three flags are 0 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_valid_i | input | 1 | Transmit header beat is present |
| tx_di_i | input | 8 | Transmit data identifier |
| tx_wc_i | input | 16 | Transmit word count |
| tx_valid_o | output | 1 | Transmit ECC result is valid |
| tx_ecc_o | output | 8 | Generated ECC byte |
| rx_valid_i | input | 1 | Received header beat is present |
| rx_di_i | input | 8 | Received data identifier |
| rx_wc_i | input | 16 | Received word count |
| rx_ecc_i | input | 8 | Received ECC byte |
| rx_valid_o | output | 1 | Receive result is valid |
| rx_di_o | output | 8 | Corrected data identifier |
| rx_wc_o | output | 16 | Corrected word count |
| rx_ok_o | output | 1 | Syndrome was zero |
| rx_fixed_o | output | 1 | One bit error was found and handled |
| rx_bad_o | output | 1 | Error could not be corrected |

## Verification
The assertions assume that the valid inputs are never unknown after reset. They also assume that a header's data and ECC are presented in the same beat as their valid, because the pass-through checks compare the output with the input of the previous cycle. The stimulus is driven on the falling edge. It covers every single header-bit flip and every single parity-bit flip on several headers. It also covers sampled double flips, both within the header and across header and ECC, with nonzero ECC bits 7:6 on clean headers and idle gaps between beats. The double flips are chosen so that none of them aliases to a correctable pattern. The reference model repairs errors by trial inversion rather than by syndrome lookup.

// File: rtl/hdr_ecc_pkg.sv
// Package: shared widths, column-code generator, parity function and the
// syndrome class type for the header ECC block.
// Assumes a 24-bit header protected by 6 parity bits in an 8-bit byte.
package hdr_ecc_pkg;

    localparam int DI_W  = 8;
    localparam int WC_W  = 16;
    localparam int HDR_W = DI_W + WC_W;
    localparam int PAR_W = 6;
    localparam int ECC_W = 8;

    // Header layout: word count above the data identifier.
    typedef struct packed {
        logic [WC_W-1:0] wc;
        logic [DI_W-1:0] di;
    } hdr_t;

    typedef enum logic [1:0] {
        CLS_OK       = 2'd0,
        CLS_FIX_DATA = 2'd1,
        CLS_FIX_ECC  = 2'd2,
        CLS_BAD      = 2'd3
    } syn_class_e;

    // Column code of header bit idx: weight-3 codes in ascending order,
    // followed by weight-5 codes in ascending order.
    function automatic logic [PAR_W-1:0] col_code(input int idx);
        logic [PAR_W-1:0] res;
        int               n;
        int               w;
        res = '0;
        n   = 0;
        for (int pass = 0; pass < 2; pass++) begin
            w = (pass == 0) ? 3 : 5;
            for (int c = 1; c < (1 << PAR_W); c++) begin
                if ($countones(c[PAR_W-1:0]) == w) begin
                    if (n == idx) begin
                        res = c[PAR_W-1:0];
                    end
                    n++;
                end
            end
        end
        return res;
    endfunction

    // Mask of header bits feeding parity bit j.
    function automatic logic [HDR_W-1:0] par_mask(input int j);
        logic [HDR_W-1:0] m;
        logic [PAR_W-1:0] code;
        m = '0;
        for (int i = 0; i < HDR_W; i++) begin
            code = col_code(i);
            m[i] = code[j];
        end
        return m;
    endfunction

endpackage

// File: rtl/hdr_ecc_parity.sv
// Module: hdr_ecc_parity
// Purely combinational parity generator: each parity bit is the XOR of the
// header bits selected by its constant column mask.
// Assumes the column codes of hdr_ecc_pkg; no state, no clock.
module hdr_ecc_parity
    import hdr_ecc_pkg::*;
(
    input  logic [HDR_W-1:0] data_i,
    output logic [PAR_W-1:0] par_o
);

    genvar j;
    generate
        for (j = 0; j < PAR_W; j++) begin : g_par
            localparam logic [HDR_W-1:0] MASK = par_mask(j);
            // XOR-reduce the selected header bits for parity bit j
            always_comb begin
                par_o[j] = ^(data_i & MASK);
            end
        end
    endgenerate

endmodule

// File: rtl/hdr_ecc_syndrome_decode.sv
// Module: hdr_ecc_syndrome_decode
// Combinational syndrome decoder. Compares the syndrome with every header
// column code to build a one-hot flip mask, then classifies the syndrome
// as clean, header-bit error, parity-bit error or uncorrectable.
// Assumes all header column codes are distinct and of weight 3 or 5, so a
// weight-1 syndrome never matches a header column.
module hdr_ecc_syndrome_decode
    import hdr_ecc_pkg::*;
(
    input  logic [PAR_W-1:0] syn_i,
    output logic [HDR_W-1:0] flip_o,
    output syn_class_e       cls_o
);

    genvar i;
    generate
        for (i = 0; i < HDR_W; i++) begin : g_col
            localparam logic [PAR_W-1:0] CODE = col_code(i);
            // Mark header bit i when the syndrome points at its column
            always_comb begin
                flip_o[i] = (syn_i == CODE);
            end
        end
    endgenerate

    logic hit_data;
    logic hit_ecc;

    // Detect which kind of single error, if any, the syndrome names
    always_comb begin
        hit_data = |flip_o;
        hit_ecc  = (syn_i != '0) && ((syn_i & (syn_i - 1'b1)) == '0);
    end

    // Classify the syndrome into one of four outcomes
    always_comb begin
        if (syn_i == '0) begin
            cls_o = CLS_OK;
        end else if (hit_data) begin
            cls_o = CLS_FIX_DATA;
        end else if (hit_ecc) begin
            cls_o = CLS_FIX_ECC;
        end else begin
            cls_o = CLS_BAD;
        end
    end

endmodule

// File: rtl/hdr_ecc_corrector.sv
// Module: hdr_ecc_corrector (top)
// Transmit path: registers the ECC byte generated from a header.
// Receive path: recomputes parity, forms the syndrome, corrects a single
// header-bit error, and registers the header with one of three flags.
// Assumes inputs are sampled only when their valid is high; one-cycle
// latency on both paths; synchronous active-low reset.
module hdr_ecc_corrector
    import hdr_ecc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_valid_i,
    input  logic [DI_W-1:0]  tx_di_i,
    input  logic [WC_W-1:0]  tx_wc_i,
    output logic             tx_valid_o,
    output logic [ECC_W-1:0] tx_ecc_o,
    input  logic             rx_valid_i,
    input  logic [DI_W-1:0]  rx_di_i,
    input  logic [WC_W-1:0]  rx_wc_i,
    input  logic [ECC_W-1:0] rx_ecc_i,
    output logic             rx_valid_o,
    output logic [DI_W-1:0]  rx_di_o,
    output logic [WC_W-1:0]  rx_wc_o,
    output logic             rx_ok_o,
    output logic             rx_fixed_o,
    output logic             rx_bad_o
);

    localparam int PAD_W = ECC_W - PAR_W;

    hdr_t             tx_hdr;
    hdr_t             rx_hdr;
    hdr_t             rx_fix;
    logic [PAR_W-1:0] tx_par;
    logic [PAR_W-1:0] rx_par;
    logic [PAR_W-1:0] rx_syn;
    logic [HDR_W-1:0] rx_flip;
    syn_class_e       rx_cls;
    logic             ecc_hi_unused;

    // Pack the identifier and word count into the fixed header order
    always_comb begin
        tx_hdr.di = tx_di_i;
        tx_hdr.wc = tx_wc_i;
        rx_hdr.di = rx_di_i;
        rx_hdr.wc = rx_wc_i;
    end

    // Received ECC bits above the parity field do not take part
    assign ecc_hi_unused = ^rx_ecc_i[ECC_W-1:PAR_W];

    hdr_ecc_parity u_tx_par (
        .data_i (tx_hdr),
        .par_o  (tx_par)
    );

    hdr_ecc_parity u_rx_par (
        .data_i (rx_hdr),
        .par_o  (rx_par)
    );

    // Syndrome: recomputed parity against received parity bits
    always_comb begin
        rx_syn = rx_par ^ rx_ecc_i[PAR_W-1:0];
    end

    hdr_ecc_syndrome_decode u_dec (
        .syn_i  (rx_syn),
        .flip_o (rx_flip),
        .cls_o  (rx_cls)
    );

    // Apply the flip mask only for a header-bit error
    always_comb begin
        rx_fix = (rx_cls == CLS_FIX_DATA) ? hdr_t'(rx_hdr ^ rx_flip) : rx_hdr;
    end

    // Transmit result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid_o <= 1'b0;
            tx_ecc_o   <= '0;
        end else begin
            tx_valid_o <= tx_valid_i;
            if (tx_valid_i) begin
                tx_ecc_o <= {{PAD_W{1'b0}}, tx_par};
            end
        end
    end

    // Receive result register with flags qualified by valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid_o <= 1'b0;
            rx_di_o    <= '0;
            rx_wc_o    <= '0;
            rx_ok_o    <= 1'b0;
            rx_fixed_o <= 1'b0;
            rx_bad_o   <= 1'b0;
        end else begin
            rx_valid_o <= rx_valid_i;
            rx_ok_o    <= rx_valid_i && (rx_cls == CLS_OK);
            rx_fixed_o <= rx_valid_i && ((rx_cls == CLS_FIX_DATA) || (rx_cls == CLS_FIX_ECC));
            rx_bad_o   <= rx_valid_i && (rx_cls == CLS_BAD);
            if (rx_valid_i) begin
                rx_di_o <= rx_fix.di;
                rx_wc_o <= rx_fix.wc;
            end
        end
    end

    // ---------------- assertions ----------------
    p_tx_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_i |=> tx_valid_o);

    p_rx_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_i |=> rx_valid_o);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid_o |-> !(rx_ok_o || rx_fixed_o || rx_bad_o));

    p_one_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> ($countones({rx_ok_o, rx_fixed_o, rx_bad_o}) == 1));

    p_ok_unchanged_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_i && (rx_syn == '0) |=> ({rx_wc_o, rx_di_o} == $past({rx_wc_i, rx_di_i})) && rx_ok_o);

    p_bad_unchanged_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_bad_o |-> ({rx_wc_o, rx_di_o} == $past({rx_wc_i, rx_di_i})));

    p_fix_one_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fixed_o |-> ($countones({rx_wc_o, rx_di_o} ^ $past({rx_wc_i, rx_di_i})) <= 1));

    p_tx_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o |-> (tx_ecc_o[ECC_W-1:PAR_W] == '0));

endmodule

// File: tb/hdr_ecc_corrector_bench.sv
module hdr_ecc_corrector_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_valid_i = 1'b0;
    logic [7:0]  tx_di_i = '0;
    logic [15:0] tx_wc_i = '0;
    logic        tx_valid_o;
    logic [7:0]  tx_ecc_o;
    logic        rx_valid_i = 1'b0;
    logic [7:0]  rx_di_i = '0;
    logic [15:0] rx_wc_i = '0;
    logic [7:0]  rx_ecc_i = '0;
    logic        rx_valid_o;
    logic [7:0]  rx_di_o;
    logic [15:0] rx_wc_o;
    logic        rx_ok_o;
    logic        rx_fixed_o;
    logic        rx_bad_o;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    hdr_ecc_corrector u_hdr_ecc_corrector (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_valid_i (tx_valid_i),
        .tx_di_i    (tx_di_i),
        .tx_wc_i    (tx_wc_i),
        .tx_valid_o (tx_valid_o),
        .tx_ecc_o   (tx_ecc_o),
        .rx_valid_i (rx_valid_i),
        .rx_di_i    (rx_di_i),
        .rx_wc_i    (rx_wc_i),
        .rx_ecc_i   (rx_ecc_i),
        .rx_valid_o (rx_valid_o),
        .rx_di_o    (rx_di_o),
        .rx_wc_o    (rx_wc_o),
        .rx_ok_o    (rx_ok_o),
        .rx_fixed_o (rx_fixed_o),
        .rx_bad_o   (rx_bad_o)
    );

    // Column codes from R1, listed by header bit
    logic [5:0] codes [24] = '{6'h07, 6'h0B, 6'h0D, 6'h0E, 6'h13, 6'h15, 6'h16, 6'h19,
                               6'h1A, 6'h1C, 6'h23, 6'h25, 6'h26, 6'h29, 6'h2A, 6'h2C,
                               6'h31, 6'h32, 6'h34, 6'h38, 6'h1F, 6'h2F, 6'h37, 6'h3B};

    function automatic logic [5:0] m_ecc(input logic [23:0] d);
        logic [5:0] r = '0;
        for (int i = 0; i < 24; i++) if (d[i]) r = r ^ codes[i];
        return r;
    endfunction

    // Expectations for the beat driven one edge earlier
    logic        e_tx_v = 0, e_rx_v = 0;
    logic [7:0]  e_tx_ecc;
    logic [23:0] e_hdr;
    logic        e_ok, e_fix, e_bad;
    string       e_tx_tag, e_rx_tag;

    task automatic check(input bit cond, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_now();
        check(tx_valid_o === e_tx_v, "R9", "tx_valid", 32'(tx_valid_o), 32'(e_tx_v));
        check(rx_valid_o === e_rx_v, "R9", "rx_valid", 32'(rx_valid_o), 32'(e_rx_v));
        if (e_tx_v) begin
            check(tx_ecc_o[5:0] === e_tx_ecc[5:0], e_tx_tag, "tx_ecc", 32'(tx_ecc_o), 32'(e_tx_ecc));
            check(tx_ecc_o[7:6] === 2'b00, "R2", "tx_ecc_top", 32'(tx_ecc_o[7:6]), 0);
        end
        if (e_rx_v) begin
            check({rx_wc_o, rx_di_o} === e_hdr, e_rx_tag, "header", 32'({rx_wc_o, rx_di_o}), 32'(e_hdr));
            check({rx_ok_o, rx_fixed_o, rx_bad_o} === {e_ok, e_fix, e_bad}, e_rx_tag, "flags",
                  32'({rx_ok_o, rx_fixed_o, rx_bad_o}), 32'({e_ok, e_fix, e_bad}));
        end else begin
            check({rx_ok_o, rx_fixed_o, rx_bad_o} === 3'b000, "R9", "idle flags",
                  32'({rx_ok_o, rx_fixed_o, rx_bad_o}), 0);
        end
    endtask

    task automatic step(input bit tv, input logic [7:0] tdi, input logic [15:0] twc, input string ttag,
                        input bit rv, input logic [7:0] rdi, input logic [15:0] rwc, input logic [7:0] recc);
        logic [23:0] d;
        logic [5:0]  s;
        int          found;
        @(negedge clk);
        compare_now();
        tx_valid_i = tv; tx_di_i = tdi; tx_wc_i = twc;
        rx_valid_i = rv; rx_di_i = rdi; rx_wc_i = rwc; rx_ecc_i = recc;
        e_tx_v = tv;
        e_tx_ecc = {2'b00, m_ecc({twc, tdi})};
        e_tx_tag = ttag;
        e_rx_v = rv;
        d = {rwc, rdi};
        s = m_ecc(d) ^ recc[5:0];
        {e_ok, e_fix, e_bad} = 3'b000;
        e_hdr = d;
        if (s == 0) begin
            e_ok = 1; e_rx_tag = (recc[7:6] != 0) ? "R8" : "R4";
        end else begin
            found = -1;
            for (int i = 0; i < 24; i++) if (m_ecc(d ^ (24'd1 << i)) == recc[5:0]) found = i;
            if (found >= 0) begin
                e_fix = 1; e_hdr = d ^ (24'd1 << found); e_rx_tag = "R5";
            end else if ($countones(s) == 1) begin
                e_fix = 1; e_rx_tag = "R6";
            end else begin
                e_bad = 1; e_rx_tag = "R7";
            end
        end
    endtask

    task automatic idle();
        step(0, 0, 0, "R1", 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [23:0] hdrs [5];
        logic [23:0] h;
        logic [7:0]  good;
        hdrs[0] = 24'h000000; hdrs[1] = 24'hFFFFFF; hdrs[2] = 24'h12345A;
        hdrs[3] = 24'($urandom); hdrs[4] = 24'($urandom);

        // R10: outputs quiet under reset, even with valid inputs driven
        tx_valid_i = 1; rx_valid_i = 1; rx_ecc_i = 8'h3F;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(tx_valid_o === 0 && rx_valid_o === 0, "R10", "valids in reset",
              32'({tx_valid_o, rx_valid_o}), 0);
        check({rx_ok_o, rx_fixed_o, rx_bad_o} === 0, "R10", "flags in reset",
              32'({rx_ok_o, rx_fixed_o, rx_bad_o}), 0);
        tx_valid_i = 0; rx_valid_i = 0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        e_tx_v = 0; e_rx_v = 0;

        // R3: field placement, known ECC values
        step(1, 8'h01, 16'h0000, "R3", 0, 0, 0, 0);
        step(1, 8'h00, 16'h0001, "R3", 0, 0, 0, 0);
        step(1, 8'h00, 16'h0100, "R3", 0, 0, 0, 0);
        step(1, 8'h80, 16'h8000, "R3", 0, 0, 0, 0);
        idle();
        // R1: random headers on the transmit path
        for (int k = 0; k < 40; k++) begin
            h = 24'($urandom);
            step(1, h[7:0], h[23:8], "R1", 0, 0, 0, 0);
        end
        idle();

        for (int n = 0; n < 5; n++) begin
            h = hdrs[n];
            good = {2'b00, m_ecc(h)};
            // R4 clean, R8 top ECC bits set on clean headers
            step(1, h[7:0], h[23:8], "R1", 1, h[7:0], h[23:8], good);
            step(0, 0, 0, "R1", 1, h[7:0], h[23:8], good | 8'hC0);
            step(0, 0, 0, "R1", 1, h[7:0], h[23:8], good | 8'h40);
            idle();
            // R5: every single header-bit flip
            for (int i = 0; i < 24; i++) begin
                h = hdrs[n] ^ (24'd1 << i);
                step(0, 0, 0, "R1", 1, h[7:0], h[23:8], good);
            end
            // R6: every single ECC-bit flip
            for (int j = 0; j < 6; j++) begin
                step(0, 0, 0, "R1", 1, hdrs[n][7:0], hdrs[n][23:8], good ^ (8'd1 << j));
            end
            idle();
            // R7: sampled double flips
            for (int i = 0; i < 24; i++) begin
                h = hdrs[n] ^ (24'd1 << i) ^ (24'd1 << ((i + 7) % 24));
                step(0, 0, 0, "R1", 1, h[7:0], h[23:8], good);
                h = hdrs[n] ^ (24'd1 << i);
                step(0, 0, 0, "R1", 1, h[7:0], h[23:8], good ^ (8'd1 << (i % 6)));
            end
            idle();
        end
        // Back-to-back mixed traffic on both paths
        for (int k = 0; k < 60; k++) begin
            h = 24'($urandom);
            good = {2'b00, m_ecc(h)};
            step(1, h[7:0], h[23:8], "R1", k[0], h[7:0] ^ 8'(k[2]), h[23:8], good ^ 8'(k[5:3]));
        end
        idle();
        idle();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule